// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block keeps the single reservation that one processor holds between a load-locked access and the store-conditional that follows it. A load-locked request records the physical address, rounded down to its 16-byte granule, and arms a lock flag. A later store-conditional is checked against that reservation. The block then decides whether the store goes to memory and returns a result code together with the lock flag value left behind.

An external clear input lets a coherence agent drop the reservation. Uncacheable store-conditionals bypass the check. A saturating counter of consecutive failed store-conditionals raises a one-cycle warning each time its value reaches a whole multiple of a configurable period, which helps expose livelock.

Requests use a valid/ready handshake. Only store-conditionals produce a decision. The decision appears one cycle after acceptance and is held until the consumer takes it.

Top module: `resv_monitor`

## Requirements
- R1: A request with `req_kind` = 0 is a load-locked access. When it is accepted, the lock address becomes `req_paddr` with its low 4 bits cleared and the lock flag becomes 1. It produces no decision (`dec_valid` stays 0).
- R2: A request with `req_kind` = 1 and `req_uncached` = 1 skips the reservation check. Its decision has `dec_issue` = 1 and `dec_code` = 2 (result register not written). The lock flag is left unchanged.
- R3: A cacheable store-conditional (`req_kind` = 1, `req_uncached` = 0) passes when the lock flag is 1 and its address with the low 4 bits cleared equals the lock address. Its decision has `dec_issue` = 1 and `dec_code` = 1, and the lock flag stays 1.
- R4: A cacheable store-conditional that does not pass gets `dec_code` = 0 and `dec_issue` = 0, and the lock flag is cleared.
- R5: The decision (`dec_valid`, `dec_issue`, `dec_code`, `dec_flag`) is registered one cycle after the store-conditional is accepted. It holds steady while `dec_ready` is 0. `req_ready` is 1 exactly when no decision is waiting or `dec_ready` is 1.
- R6: `clr_resv` clears the lock flag, but a load-locked access accepted in the same cycle wins and leaves the flag set. A store-conditional in the same cycle is checked against the flag as it stood before the clear. `dec_flag` reports the lock flag after the whole cycle's update, including the clear.
- R7: Every failing cacheable store-conditional adds one to a consecutive-failure count. Any passing or uncacheable store-conditional sets the count back to zero.
- R8: When a failure brings the count to a whole multiple of `WARN_PERIOD` (default 100000), `warn_pulse` is 1 for exactly the one cycle in which that failure's decision first appears.
- R9: The failure count saturates at 2^`CNT_W`−1 (default 32 bits) and does not wrap. While it is saturated, no further warnings occur.
- R10: After reset the lock flag, lock address and failure count are zero, `dec_valid` and `warn_pulse` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 1 | 0 = load-locked, 1 = store-conditional |
| req_paddr | input | ADDR_W (40) | Physical address of the request |
| req_uncached | input | 1 | Store-conditional targets uncacheable space |
| clr_resv | input | 1 | External reservation clear |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_issue | output | 1 | Store-conditional is sent to memory |
| dec_code | output | 2 | 0 failed, 1 passed, 2 no register update |
| dec_flag | output | 1 | Lock flag after the store-conditional |
| warn_pulse | output | 1 | One-cycle livelock warning |

## Verification
The bench targets addresses that share a granule but differ in their low bits, which must pass. A design that compared full addresses would fail them. It also targets neighbouring granules, which must fail, and a design that masked too many bits would let them pass. Clear and load-locked are driven in the same cycle, and a design with the wrong priority would leave no reservation behind. A clear is also driven alongside a passing store-conditional, and a design that applied the clear first would fail that store. Long runs of failures are broken by one success and then carried past saturation, using a reduced period and counter width. A counter that was never zeroed, or one that wrapped, would show up as a warning in the wrong place or an extra warning. A stalled decision must hold steady with `req_ready` low, or decisions would be lost or overwritten.

// File: rtl/resv_pkg.sv
package resv_pkg;

  localparam logic KIND_LOAD_LOCK  = 1'b0;
  localparam logic KIND_STORE_COND = 1'b1;

  typedef enum logic [1:0] {
    SC_FAILED = 2'd0,
    SC_DONE   = 2'd1,
    SC_NO_WB  = 2'd2
  } sc_code_e;

endpackage

// File: rtl/resv_rst_sync.sv
module resv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/resv_lock_reg.sv
module resv_lock_reg #(
  parameter int ADDR_W    = 40,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              drop_i,
  output logic              flag_o,
  output logic              flag_d_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

  logic              flag_q, flag_d, flag_en;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    flag_d  = flag_q;
    addr_d  = addr_q;
    if (set_i) begin
      flag_d = 1'b1;
      addr_d = set_addr_i;
    end else if (drop_i) begin
      flag_d = 1'b0;
    end
    flag_en = set_i || drop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (set_i)   addr_q <= addr_d;
    end
  end

  assign flag_o   = flag_q;
  assign flag_d_o = flag_d;
  assign addr_o   = addr_q;

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & LOW_MASK) == '0);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/resv_fail_ctr.sv
module resv_fail_ctr #(
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic zero_i,
  output logic hit_o
);

  localparam int              PH_W    = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             sat, step, cnt_en;

  always_comb begin
    sat    = (cnt_q == CNT_MAX);
    step   = inc_i && !sat;
    cnt_en = zero_i || step;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    if (zero_i) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      ph_d  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign hit_o = step && (ph_q == PH_LAST);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_i && zero_i));

  a_r7_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (cnt_q == '0));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !zero_i) |=> (cnt_q == CNT_MAX));

  a_r8_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_LAST);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W      = 40,
  parameter int GRAN_BITS   = 4,
  parameter int CNT_W       = 32,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_paddr,
  input  logic              req_uncached,
  input  logic              clr_resv,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_issue,
  output logic [1:0]        dec_code,
  output logic              dec_flag,
  output logic              warn_pulse
);

  import resv_pkg::*;

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

  logic              rst_ns;
  logic              acc, ll_acc, sc_acc, hit, sc_pass, sc_fail;
  logic [ADDR_W-1:0] req_gran, lock_addr;
  logic              lock_flag, lock_flag_d, warn_hit;

  logic     dv_q, dv_d, iss_q, iss_d, flg_q, flg_d, warn_q, warn_d;
  sc_code_e code_q, code_d;

  resv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign req_ready = !dv_q || dec_ready;

  always_comb begin
    acc      = req_valid && req_ready;
    ll_acc   = acc && (req_kind == KIND_LOAD_LOCK);
    sc_acc   = acc && (req_kind == KIND_STORE_COND);
    req_gran = req_paddr & ~LOW_MASK;
    hit      = lock_flag && (lock_addr == req_gran);
    sc_pass  = sc_acc && (req_uncached || hit);
    sc_fail  = sc_acc && !req_uncached && !hit;
  end

  resv_lock_reg #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_ns),
    .set_i      (ll_acc),
    .set_addr_i (req_gran),
    .drop_i     (sc_fail || clr_resv),
    .flag_o     (lock_flag),
    .flag_d_o   (lock_flag_d),
    .addr_o     (lock_addr)
  );

  resv_fail_ctr #(
    .CNT_W       (CNT_W),
    .WARN_PERIOD (WARN_PERIOD)
  ) u_fails (
    .clk    (clk),
    .rst_n  (rst_ns),
    .inc_i  (sc_fail),
    .zero_i (sc_pass),
    .hit_o  (warn_hit)
  );

  always_comb begin
    dv_d   = dv_q;
    iss_d  = iss_q;
    code_d = code_q;
    flg_d  = flg_q;
    if (sc_acc) begin
      dv_d  = 1'b1;
      iss_d = !sc_fail;
      flg_d = lock_flag_d;
      if (req_uncached) code_d = SC_NO_WB;
      else if (hit)     code_d = SC_DONE;
      else              code_d = SC_FAILED;
    end else if (dec_ready) begin
      dv_d = 1'b0;
    end
    warn_d = warn_hit;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dv_q   <= 1'b0;
      iss_q  <= 1'b0;
      code_q <= SC_FAILED;
      flg_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      dv_q   <= dv_d;
      warn_q <= warn_d;
      if (sc_acc) begin
        iss_q  <= iss_d;
        code_q <= code_d;
        flg_q  <= flg_d;
      end
    end
  end

  assign dec_valid  = dv_q;
  assign dec_issue  = iss_q;
  assign dec_code   = code_q;
  assign dec_flag   = flg_q;
  assign warn_pulse = warn_q;

  a_r1_no_decision: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_ready && req_kind == KIND_LOAD_LOCK) |=> !dec_valid);

  a_r2_uncached: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_ready && req_kind == KIND_STORE_COND && req_uncached)
    |=> (dec_valid && dec_issue && dec_code == 2'd2));

  a_r4_fail_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    (dec_valid && dec_code == 2'd0) |-> (!dec_issue && !dec_flag));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_code) &&
                                   $stable(dec_issue) && $stable(dec_flag)));

  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_ns)
    (dec_valid && !dec_ready) |-> !req_ready);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_ns)
    warn_pulse |=> !warn_pulse);

  a_r8_on_failure: assert property (@(posedge clk) disable iff (!rst_ns)
    warn_pulse |-> (dec_valid && dec_code == 2'd0));

endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;

  localparam int AW     = 40;
  localparam int CW     = 12;
  localparam int PERIOD = 1000;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_kind = 1'b0, req_uncached = 1'b0;
  logic          clr_resv = 1'b0, dec_ready = 1'b1;
  logic [AW-1:0] req_paddr = '0;
  logic          req_ready, dec_valid, dec_issue, dec_flag, warn_pulse;
  logic [1:0]    dec_code;

  int checks = 0;
  int fails  = 0;

  bit            m_flag = 1'b0;
  logic [AW-1:0] m_addr = '0;
  int            m_cnt  = 0;

  always #10 clk = ~clk;

  resv_monitor #(
    .ADDR_W      (AW),
    .GRAN_BITS   (4),
    .CNT_W       (CW),
    .WARN_PERIOD (PERIOD)
  ) i_resv_monitor (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_paddr    (req_paddr),
    .req_uncached (req_uncached),
    .clr_resv     (clr_resv),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .dec_issue    (dec_issue),
    .dec_code     (dec_code),
    .dec_flag     (dec_flag),
    .warn_pulse   (warn_pulse)
  );

  function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
    return a & ~40'hF;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Drive one request at a falling edge, sample at the next falling edge.
  task automatic op(input logic kind, input logic [AW-1:0] a,
                    input logic unc, input logic clr, input string tag);
    bit       e_pass, e_warn, e_flag;
    int       e_code;
    e_pass = 0; e_warn = 0; e_code = 0;
    if (kind) begin
      e_pass = unc || (m_flag && gran(a) == m_addr);
      e_code = unc ? 2 : (e_pass ? 1 : 0);
      if (e_pass) m_cnt = 0;
      else if (m_cnt < CMAX) begin
        m_cnt++;
        e_warn = (m_cnt % PERIOD) == 0;
      end
      if (!e_pass) m_flag = 0;
      if (clr) m_flag = 0;
    end else begin
      m_flag = 1;
      m_addr = gran(a);
    end
    e_flag = m_flag;
    req_valid = 1'b1; req_kind = kind; req_paddr = a;
    req_uncached = unc; clr_resv = clr;
    @(negedge clk);
    req_valid = 1'b0; req_uncached = 1'b0; clr_resv = 1'b0;
    if (!kind) begin
      chk(dec_valid, 0, {tag, " R1 load-locked gives no decision"});
    end else begin
      chk(dec_valid, 1, {tag, " R5 decision one cycle later"});
      chk(dec_issue, e_pass, {tag, " R2/R3/R4 issue"});
      chk(dec_code, e_code, {tag, " R2/R3/R4 code"});
      chk(dec_flag, e_flag, {tag, " R6 flag after update"});
      chk(warn_pulse, e_warn, {tag, " R8 warn pulse"});
    end
  endtask

  task automatic clear_only();
    m_flag = 0;
    clr_resv = 1'b1;
    @(negedge clk);
    clr_resv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [AW-1:0] base;
    base = 40'h12_3456_7800;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(req_ready, 1, "R10 ready after reset");
    chk(dec_valid, 0, "R10 no decision after reset");
    chk(warn_pulse, 0, "R10 no warn after reset");
    op(1, 40'h0, 0, 0, "R10 flag clear after reset");

    // R1 / R3: same granule, different offset passes
    op(0, base + 40'h3, 0, 0, "R1 arm");
    op(1, base + 40'hC, 0, 0, "R3 same granule");
    op(1, base + 40'hF, 0, 0, "R3 again");
    // R4: neighbouring granule fails
    op(1, base + 40'h10, 0, 0, "R4 next granule");
    op(1, base, 0, 0, "R4 flag now clear");
    // R2: uncached bypass, flag kept
    op(0, base, 0, 0, "R2 arm");
    op(1, base + 40'h1000, 1, 0, "R2 uncached");
    op(1, base + 40'h8, 0, 0, "R2 flag unchanged");
    // R6: clear + load-locked same cycle -> load-locked wins
    op(0, base + 40'h20, 0, 1, "R6 ll wins");
    op(1, base + 40'h2F, 0, 0, "R6 reservation held");
    // R6: clear with passing store-conditional
    op(1, base + 40'h20, 0, 1, "R6 sc before clear");
    op(1, base + 40'h20, 0, 0, "R6 cleared after");
    op(0, base, 0, 0, "R6 arm");
    clear_only();
    op(1, base, 0, 0, "R6 clear alone");

    // R5 back-pressure
    op(0, base, 0, 0, "R5 arm");
    dec_ready = 1'b0;
    op(1, base, 0, 0, "R5 stalled");
    chk(req_ready, 0, "R5 ready low while stalled");
    @(negedge clk);
    chk(dec_valid, 1, "R5 decision held");
    chk(dec_code, 1, "R5 code held");
    dec_ready = 1'b1;
    @(negedge clk);
    chk(dec_valid, 0, "R5 decision taken");
    chk(req_ready, 1, "R5 ready again");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = base + AW'(($urandom % 4) << 4) + AW'($urandom % 16);
      op(1'($urandom % 2), a, 1'(($urandom % 8) == 0),
         1'(($urandom % 8) == 0), "random");
    end

    // R7 / R8 / R9 failure runs
    op(1, base, 1, 0, "R7 zero via uncached");
    op(0, base, 0, 0, "R7 arm");
    for (int i = 0; i < PERIOD - 1; i++) op(1, base + 40'h40, 0, 0, "R7 fail run");
    op(0, base, 0, 0, "R7 rearm");
    op(1, base, 0, 0, "R7 success resets count");
    for (int i = 0; i < PERIOD; i++) op(1, base + 40'h40, 0, 0, "R8 fail run");
    for (int i = 0; i < 5200; i++) op(1, base + 40'h40, 0, 0, "R9 saturating run");
    op(1, base + 40'h40, 0, 0, "R9 final");

    summary();
  end

endmodule